// File: doc/BRIEF.md
# Display Interface Timing Engine

This block generates the synchronisation and data-enable timing for a panel interface, running on the pixel clock. A horizontal counter tracks the position within the current line. A second counter tracks the position within the whole frame, counted in pixel clocks. Vertical sync and the vertical active window are therefore given as absolute pixel-clock offsets from the leading edge of vertical sync. Software normally computes these offsets as a line count times the horizontal total, plus any skew or porch adjustment the panel needs.

Inside the active window the block passes the pixel source through. When the source underflows inside the window, it drives a programmable underflow colour instead. Outside the window it drives a programmable border colour. Two programmable bits select the sense of each sync output. A two-bit enable gates a frame counter and a line counter.

Timing settings are captured into shadow registers only at a frame boundary. Clearing the enable lets the current frame finish before the engine stops, so that the next configuration starts from a clean frame. Every output is registered: output cycle t+1 reflects the engine position at cycle t.

Top module: `disp_timing_engine`

## Requirements
- R1: While running, hsync is active during the first `hs_pulse` clocks of every line, and lines repeat every `h_total` clocks. Line position 0 is the leading edge of hsync.
- R2: While running, vsync is active during the first `v_pulse` clocks of every frame, and frames repeat every `v_period` clocks. Both counts are pixel clocks from the frame start.
- R3: `de` is high only when the line position lies in [`h_act_first`, `h_act_last`] and the frame position lies in [`v_act_first`, `v_act_last`]. Both ranges are inclusive and are measured from the respective sync leading edge.
- R4: `hs_invert`=1 makes hsync active-low and `vs_invert`=1 makes vsync active-low. With a bit at 0, that sync is active-high. The two bits act independently.
- R5: `pix_out` selects among three values:
  - inside the active window with `src_valid`=1, it equals `src_pixel`;
  - inside the window with `src_valid`=0, it equals `underrun_rgb`;
  - outside the window, or while idle, it equals `border_rgb`.
- R6: Clearing `eng_en` while running does not stop the engine mid-frame. `running` stays 1 until the last clock of the frame and falls on the next clock. Setting `eng_en` while idle starts a frame on the next clock.
- R7: Timing and polarity inputs take effect only at a frame boundary while running. While idle they follow the inputs with one clock of delay.
- R8: `frame_done` pulses for one clock at each vsync leading edge (frame position 0). It appears together with the first active vsync clock.
- R9: `count_en` bit 0 gates the frame counter, which increments at each frame start. `count_en` bit 1 gates the line counter, which increments at each line start. Both counters wrap.
- R10: Synchronous active-high reset clears the state. On the first clock after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_en | input | 1 | Engine enable; clearing it stops the engine at the frame end |
| hs_pulse | input | HW | Hsync width in clocks |
| h_total | input | HW | Line period in clocks |
| h_act_first | input | HW | First active line position |
| h_act_last | input | HW | Last active line position |
| v_period | input | FW | Frame period in clocks |
| v_pulse | input | FW | Vsync width in clocks |
| v_act_first | input | FW | First active frame position |
| v_act_last | input | FW | Last active frame position |
| hs_invert | input | 1 | Hsync active-low |
| vs_invert | input | 1 | Vsync active-low |
| border_rgb | input | PIX_W | Colour driven outside the active window |
| underrun_rgb | input | PIX_W | Colour driven on underflow inside the window |
| count_en | input | 2 | Bit 0 frame counter, bit 1 line counter |
| src_valid | input | 1 | Pixel source has data this clock |
| src_pixel | input | PIX_W | Pixel from the source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | PIX_W | Output pixel |
| frame_done | output | 1 | One-clock pulse at the vsync leading edge |
| running | output | 1 | Engine is producing frames |
| frame_cnt | output | CNT_W | Frame counter |
| line_cnt | output | CNT_W | Line counter |

## Verification
The bench uses the default widths: 24-bit pixels, 16-bit counters, 12-bit line positions and 24-bit frame positions. It programs two tiny modes:
- a 10-clock line in a 60-clock frame, derived from a 5×3 display;
- an 8-clock line in a 40-clock frame.

These modes make whole frames only tens of clocks long. Several frame boundaries, a mid-frame polarity and pulse change held off by the shadow registers, and a deferred stop followed by a restart in another mode all fit within a few hundred cycles. A repeating underflow pattern on `src_valid` exercises all three pixel-mux selections, including at the inclusive window edges.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int HW = 12;
  localparam int FW = 24;

  typedef struct packed {
    logic [HW-1:0] htotal;
    logic [HW-1:0] hpulse;
    logic [HW-1:0] hfirst;
    logic [HW-1:0] hlast;
    logic [FW-1:0] vperiod;
    logic [FW-1:0] vpulse;
    logic [FW-1:0] vfirst;
    logic [FW-1:0] vlast;
    logic          hs_inv;
    logic          vs_inv;
  } dte_cfg_t;
endpackage

// File: rtl/dte_shadow.sv
module dte_shadow
  import dte_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  dte_cfg_t live,
  output dte_cfg_t cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= live;
  end
endmodule

// File: rtl/dte_position.sv
module dte_position
  import dte_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eng_en,
  input  dte_cfg_t         cfg,
  input  logic [1:0]       count_en,
  output logic             run,
  output logic [HW-1:0]    hpos,
  output logic [FW-1:0]    fpos,
  output logic             load,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] line_cnt
);
  localparam int NCNT = 2;

  logic line_end, frame_end;
  logic [NCNT-1:0] evt;
  logic [NCNT-1:0][CNT_W-1:0] cnt;

  assign line_end  = (hpos == cfg.htotal - HW'(1));
  assign frame_end = run && (fpos == cfg.vperiod - FW'(1));
  assign load      = !run || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      hpos <= '0;
      fpos <= '0;
    end else if (!run) begin
      run  <= eng_en;
      hpos <= '0;
      fpos <= '0;
    end else begin
      hpos <= line_end  ? '0 : hpos + HW'(1);
      fpos <= frame_end ? '0 : fpos + FW'(1);
      if (frame_end && !eng_en) run <= 1'b0;
    end
  end

  // event 0: frame start, event 1: line start
  assign evt[0] = run && (fpos == '0);
  assign evt[1] = run && (hpos == '0);

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                          cnt[gi] <= '0;
      else if (evt[gi] && count_en[gi]) cnt[gi] <= cnt[gi] + CNT_W'(1);
    end
  end

  assign frame_cnt = cnt[0];
  assign line_cnt  = cnt[1];
endmodule

// File: rtl/dte_outgen.sv
module dte_outgen
  import dte_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [HW-1:0]    hpos,
  input  logic [FW-1:0]    fpos,
  input  dte_cfg_t         cfg,
  input  logic             src_valid,
  input  logic [PIX_W-1:0] src_pixel,
  input  logic [PIX_W-1:0] border_rgb,
  input  logic [PIX_W-1:0] underrun_rgb,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic             frame_done
);
  logic hs_on, vs_on, win;

  assign hs_on = run && (hpos < cfg.hpulse);
  assign vs_on = run && (fpos < cfg.vpulse);
  assign win   = run && (hpos >= cfg.hfirst) && (hpos <= cfg.hlast)
                     && (fpos >= cfg.vfirst) && (fpos <= cfg.vlast);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync      <= 1'b0;
      vsync      <= 1'b0;
      de         <= 1'b0;
      pix_out    <= '0;
      frame_done <= 1'b0;
    end else begin
      hsync      <= hs_on ^ cfg.hs_inv;
      vsync      <= vs_on ^ cfg.vs_inv;
      de         <= win;
      pix_out    <= win ? (src_valid ? src_pixel : underrun_rgb) : border_rgb;
      frame_done <= run && (fpos == '0);
    end
  end
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
  import dte_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eng_en,
  input  logic [HW-1:0]    hs_pulse,
  input  logic [HW-1:0]    h_total,
  input  logic [HW-1:0]    h_act_first,
  input  logic [HW-1:0]    h_act_last,
  input  logic [FW-1:0]    v_period,
  input  logic [FW-1:0]    v_pulse,
  input  logic [FW-1:0]    v_act_first,
  input  logic [FW-1:0]    v_act_last,
  input  logic             hs_invert,
  input  logic             vs_invert,
  input  logic [PIX_W-1:0] border_rgb,
  input  logic [PIX_W-1:0] underrun_rgb,
  input  logic [1:0]       count_en,
  input  logic             src_valid,
  input  logic [PIX_W-1:0] src_pixel,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic             frame_done,
  output logic             running,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] line_cnt
);
  dte_cfg_t live_cfg, cur_cfg;
  logic [HW-1:0] hpos;
  logic [FW-1:0] fpos;
  logic          load;

  always_comb begin
    live_cfg.htotal  = h_total;
    live_cfg.hpulse  = hs_pulse;
    live_cfg.hfirst  = h_act_first;
    live_cfg.hlast   = h_act_last;
    live_cfg.vperiod = v_period;
    live_cfg.vpulse  = v_pulse;
    live_cfg.vfirst  = v_act_first;
    live_cfg.vlast   = v_act_last;
    live_cfg.hs_inv  = hs_invert;
    live_cfg.vs_inv  = vs_invert;
  end

  dte_shadow u_shadow (
    .clk (clk), .rst (rst), .load (load), .live (live_cfg), .cur (cur_cfg)
  );

  dte_position #(.CNT_W(CNT_W)) u_pos (
    .clk (clk), .rst (rst), .eng_en (eng_en), .cfg (cur_cfg),
    .count_en (count_en), .run (running), .hpos (hpos), .fpos (fpos),
    .load (load), .frame_cnt (frame_cnt), .line_cnt (line_cnt)
  );

  dte_outgen #(.PIX_W(PIX_W)) u_out (
    .clk (clk), .rst (rst), .run (running), .hpos (hpos), .fpos (fpos),
    .cfg (cur_cfg), .src_valid (src_valid), .src_pixel (src_pixel),
    .border_rgb (border_rgb), .underrun_rgb (underrun_rgb),
    .hsync (hsync), .vsync (vsync), .de (de), .pix_out (pix_out),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/dte_chk.sv
module dte_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_en,
  input logic             running,
  input logic             de,
  input logic             frame_done,
  input logic [1:0]       count_en,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] line_cnt
);
  // R3
  de_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(running));

  // R6
  stop_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> !$past(eng_en));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8
  done_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(running));

  // R9
  frame_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_cnt) |-> $past(count_en[0]));

  // R9
  line_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_cnt) |-> $past(count_en[1]));
endmodule

bind disp_timing_engine dte_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst (rst), .eng_en (eng_en), .running (running), .de (de),
  .frame_done (frame_done), .count_en (count_en),
  .frame_cnt (frame_cnt), .line_cnt (line_cnt)
);

// File: tb/sim_disp_timing_engine.sv
`timescale 1ns/1ps
module sim_disp_timing_engine;
  localparam int PIX_W = 24;
  localparam int CNT_W = 16;
  localparam int HW = dte_pkg::HW;
  localparam int FW = dte_pkg::FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eng_en = 1'b0;
  logic [HW-1:0] hs_pulse = '0, h_total = '0, h_act_first = '0, h_act_last = '0;
  logic [FW-1:0] v_period = '0, v_pulse = '0, v_act_first = '0, v_act_last = '0;
  logic hs_invert = 1'b0, vs_invert = 1'b0;
  logic [PIX_W-1:0] border_rgb = '0, underrun_rgb = '0, src_pixel = '0;
  logic [1:0] count_en = 2'b00;
  logic src_valid = 1'b0;
  logic hsync, vsync, de, frame_done, running;
  logic [PIX_W-1:0] pix_out;
  logic [CNT_W-1:0] frame_cnt, line_cnt;

  always #2.5 clk = ~clk;

  disp_timing_engine #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u0 (.*);

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference
  int m_run = 0, m_h = 0, m_f = 0;
  int s_ht = 0, s_hp = 0, s_hf = 0, s_hl = 0, s_vp = 0, s_vw = 0, s_vf = 0, s_vl = 0;
  int s_hi = 0, s_vi = 0;
  int e_hs = 0, e_vs = 0, e_de = 0, e_fd = 0, e_run = 0, e_fc = 0, e_lc = 0;
  int e_pix = 0;

  task automatic grab_cfg();
    s_ht = int'(h_total); s_hp = int'(hs_pulse); s_hf = int'(h_act_first);
    s_hl = int'(h_act_last); s_vp = int'(v_period); s_vw = int'(v_pulse);
    s_vf = int'(v_act_first); s_vl = int'(v_act_last);
    s_hi = int'(hs_invert); s_vi = int'(vs_invert);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_h = 0; m_f = 0;
      s_ht = 0; s_hp = 0; s_hf = 0; s_hl = 0; s_vp = 0; s_vw = 0; s_vf = 0; s_vl = 0;
      s_hi = 0; s_vi = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_fd = 0; e_pix = 0; e_fc = 0; e_lc = 0;
    end else begin
      bit inwin;
      inwin = (m_run == 1) && m_h >= s_hf && m_h <= s_hl && m_f >= s_vf && m_f <= s_vl;
      e_hs = ((m_run == 1 && m_h < s_hp) ? 1 : 0) ^ s_hi;
      e_vs = ((m_run == 1 && m_f < s_vw) ? 1 : 0) ^ s_vi;
      e_de = inwin ? 1 : 0;
      e_pix = inwin ? (src_valid ? int'(src_pixel) : int'(underrun_rgb)) : int'(border_rgb);
      e_fd = (m_run == 1 && m_f == 0) ? 1 : 0;
      if (m_run == 1 && m_f == 0 && count_en[0]) e_fc = (e_fc + 1) % (1 << CNT_W);
      if (m_run == 1 && m_h == 0 && count_en[1]) e_lc = (e_lc + 1) % (1 << CNT_W);
      if (m_run == 0) begin
        grab_cfg();
        if (eng_en) m_run = 1;
        m_h = 0; m_f = 0;
      end else begin
        bit endf;
        endf = (m_f == s_vp - 1);
        m_h = (m_h == s_ht - 1) ? 0 : m_h + 1;
        m_f = endf ? 0 : m_f + 1;
        if (endf) begin
          grab_cfg();
          if (!eng_en) m_run = 0;
        end
      end
    end
    e_run = m_run;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R4 R7", "hsync", int'(hsync), e_hs);
    chk("R2 R4 R7", "vsync", int'(vsync), e_vs);
    chk("R3", "de", int'(de), e_de);
    chk("R5", "pix_out", int'(pix_out), e_pix);
    chk("R8", "frame_done", int'(frame_done), e_fd);
    chk("R6", "running", int'(running), e_run);
    chk("R9", "frame_cnt", int'(frame_cnt), e_fc);
    chk("R9", "line_cnt", int'(line_cnt), e_lc);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      compare_all();
      src_valid = (cyc % 7) != 3;
      src_pixel = PIX_W'(cyc * 37 + 5);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    @(posedge clk);
    step(4);
    rst = 1'b0;
    step(1);
    // R10: first clock after reset
    chk("R10", "hsync", int'(hsync), 0);
    chk("R10", "vsync", int'(vsync), 0);
    chk("R10", "de", int'(de), 0);
    chk("R10", "pix_out", int'(pix_out), 0);
    chk("R10", "running", int'(running), 0);
    chk("R10", "frame_cnt", int'(frame_cnt), 0);

    // mode A: 5x3 active, htotal 10, vtotal 6
    h_total = 10; hs_pulse = 2; h_act_first = 3; h_act_last = 7;
    v_period = 60; v_pulse = 10; v_act_first = 20; v_act_last = 49;
    border_rgb = 24'h0a0b0c; underrun_rgb = 24'h0000ff; count_en = 2'b11;
    step(3);
    eng_en = 1'b1;
    step(85);
    // R7: mid-frame change, held until next boundary
    hs_pulse = 3; hs_invert = 1'b1;
    step(60);
    // R6: disable mid-frame
    eng_en = 1'b0;
    step(3);
    chk("R6", "running held", int'(running), 1);
    step(70);
    chk("R6", "running stopped", int'(running), 0);

    // mode B while idle, frame counter only
    h_total = 8; hs_pulse = 1; h_act_first = 2; h_act_last = 6;
    v_period = 40; v_pulse = 8; v_act_first = 16; v_act_last = 31;
    hs_invert = 1'b0; vs_invert = 1'b1; count_en = 2'b01;
    border_rgb = 24'h123456; underrun_rgb = 24'h00ff00;
    step(5);
    eng_en = 1'b1;
    step(55);
    count_en = 2'b10;
    step(60);
    count_en = 2'b00;
    step(20);
    finish_run();
  end
endmodule